// File: doc/BRIEF.md
# I2C Master Register and FIFO Bank

This block is the memory-mapped front end of an I2C master. A host drives a simple 32-bit bus with separate write and read strobes. Through it the host queues 10-bit transmit words, drains received bytes, programs control bits, and sets a receive watermark. The host also enables and acknowledges interrupt causes. A bit-level engine sits behind the block. It takes transmit words with a pop handshake and hands in received bytes with a push handshake. It also reports bus activity, arbitration loss and missing acknowledges.

Both queues are sixteen entries deep. The engine sees the head of the transmit queue combinationally. Read data on the bus is combinational from the address. A read of the receive data location pops the receive queue at the clock edge that ends the access.

Interrupt causes latch into a sticky status register. Host software acknowledges a cause by writing a one to its bit. A single interrupt line is raised when the global enable is on and any enabled cause is pending. A keyed write returns every register and both queues to their reset state.

Top module: `i2c_regbank`

## Requirements
- R1: After reset, control (0x100), global enable (0x1C), cause enable (0x28), both occupancy registers and the receive depth (0x120) read 0. Status reads 0xC0 while `eng_bus_busy` is low, and `irq` is low.
- R2: A bus write to 0x108 pushes `wdata[9:0]` into the transmit FIFO. Bit 8 marks a start and bit 9 marks a stop; both travel unchanged. The engine takes words in write order on `eng_tx_word` with `eng_tx_pop`. The FIFO holds 16 words, and a write while it is full is dropped.
- R3: `eng_rx_push` stores `eng_rx_byte` into the receive FIFO of 16 bytes. A push while that FIFO is full is dropped. A bus read of 0x10C returns the oldest byte and removes it. A read of 0x10C while the FIFO is empty returns 0 and leaves the occupancy unchanged.
- R4: Transmit occupancy (0x114) and receive occupancy (0x118) read the stored count minus one, and read 0 when their FIFO is empty.
- R5: Status (0x104) bit 2 follows `eng_bus_busy`, bit 4 is transmit full, bit 5 is receive full, bit 6 is receive empty and bit 7 is transmit empty.
- R6: Control bit 0 drives `eng_enable`. While control bit 1 is set, the transmit FIFO is held empty and bus pushes into it are ignored.
- R7: Interrupt status (0x120 is not it; 0x20) bit 0 latches `eng_arb_lost`, and bit 1 latches `eng_nack`. Bit 2 latches an empty transmit FIFO. Bit 4 latches `eng_bus_busy` low. Bit 7 latches a transmit count of at most half the depth.
- R8: Receive depth (0x120, 4 bits) is zero-based. Interrupt status bit 3 latches whenever the receive count is at least the programmed value plus one.
- R9: Interrupt status bits stay set once latched. Writing 1 to a bit at 0x20 clears it, and writing 0 leaves it unchanged. A cause still present in the same cycle wins over the clear.
- R10: `irq` is high exactly when global enable bit 31 (0x1C) is set and some bit is set in both interrupt status and cause enable (0x28, 8 bits).
- R11: Writing 0xA to 0x40 returns every register and both FIFOs to their reset state at that clock edge. Any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 9 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| eng_enable | output | 1 | Device enable to the engine |
| eng_tx_valid | output | 1 | Transmit FIFO has a word for the engine |
| eng_tx_word | output | 10 | Head transmit word (bit 8 start, bit 9 stop) |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_rx_ready | output | 1 | Receive FIFO can accept a byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_bus_busy | input | 1 | Bus busy indication from the engine |
| eng_arb_lost | input | 1 | Arbitration lost pulse |
| eng_nack | input | 1 | Transmit error or missing acknowledge pulse |
| irq | output | 1 | Interrupt request |

## Verification
Some properties hold on every cycle, and the assertions check them there. Both counts stay within the depth. A dropped push leaves a full queue full. An empty read returns zero. A latched cause survives unless its clear bit is written. The keyed reset empties everything, and `irq` stays low while the global enable is off.

Other behaviour only shows across a scenario, so the bench scenarios cover it. These include the ordering and start/stop flag integrity of queued words and the zero-based occupancy encodings. They also include the watermark threshold crossing, write-one-to-clear semantics, hold of the transmit FIFO by control bit 1, and a wrong key that leaves state intact.

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int DEPTH = 16,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          eng_enable,
  output logic          eng_tx_valid,
  output logic [9:0]    eng_tx_word,
  input  logic          eng_tx_pop,
  output logic          eng_rx_ready,
  input  logic          eng_rx_push,
  input  logic [7:0]    eng_rx_byte,
  input  logic          eng_bus_busy,
  input  logic          eng_arb_lost,
  input  logic          eng_nack,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [AW-1:0] A_GIE  = AW'('h01C);
  localparam logic [AW-1:0] A_ISR  = AW'('h020);
  localparam logic [AW-1:0] A_IER  = AW'('h028);
  localparam logic [AW-1:0] A_RST  = AW'('h040);
  localparam logic [AW-1:0] A_CTL  = AW'('h100);
  localparam logic [AW-1:0] A_STS  = AW'('h104);
  localparam logic [AW-1:0] A_TXD  = AW'('h108);
  localparam logic [AW-1:0] A_RXD  = AW'('h10C);
  localparam logic [AW-1:0] A_TXO  = AW'('h114);
  localparam logic [AW-1:0] A_RXO  = AW'('h118);
  localparam logic [AW-1:0] A_RXWM = AW'('h120);

  logic [1:0]    ctl;
  logic          gie;
  logic [7:0]    ier, isr, cause;
  logic [PW-1:0] rx_wm;
  logic [9:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire soft_rst = wr_en && addr == A_RST && wdata == 32'hA;
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire tx_push  = wr_en && addr == A_TXD && !tx_full && !ctl[1];
  wire tx_pop   = eng_tx_pop && !tx_empty && !ctl[1];
  wire rx_push  = eng_rx_push && !rx_full;
  wire rx_pop   = rd_en && addr == A_RXD && !rx_empty;
  wire rx_hit   = rx_cnt >= CW'(rx_wm) + CW'(1);
  wire [7:0] isr_clr = (wr_en && addr == A_ISR) ? wdata[7:0] : 8'h00;
  wire [CW-1:0] tx_occ = tx_empty ? '0 : tx_cnt - CW'(1);
  wire [CW-1:0] rx_occ = rx_empty ? '0 : rx_cnt - CW'(1);

  assign cause = {tx_cnt <= CW'(DEPTH / 2), 2'b00, !eng_bus_busy, rx_hit,
                  tx_empty, eng_nack, eng_arb_lost};
  assign eng_enable   = ctl[0];
  assign eng_tx_valid = !tx_empty && !ctl[1];
  assign eng_tx_word  = tx_mem[tx_rp];
  assign eng_rx_ready = !rx_full;
  assign irq          = gie && |(isr & ier);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; gie <= 1'b0; ier <= '0; isr <= '0; rx_wm <= '0;
    end else if (soft_rst) begin
      ctl <= '0; gie <= 1'b0; ier <= '0; isr <= '0; rx_wm <= '0;
    end else begin
      isr <= (isr & ~isr_clr) | cause;
      if (wr_en) begin
        if (addr == A_CTL)  ctl   <= wdata[1:0];
        if (addr == A_GIE)  gie   <= wdata[31];
        if (addr == A_IER)  ier   <= wdata[7:0];
        if (addr == A_RXWM) rx_wm <= wdata[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (soft_rst || ctl[1]) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PW'(1);
      if (tx_pop)  tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (soft_rst) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + PW'(1);
      if (rx_pop)  rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wdata[9:0];
    if (rx_push) rx_mem[rx_wp] <= eng_rx_byte;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL:  rdata = 32'(ctl);
      A_STS:  rdata = {24'h0, tx_empty, rx_empty, rx_full, tx_full, 1'b0,
                       eng_bus_busy, 2'b00};
      A_RXD:  rdata = rx_empty ? 32'h0 : 32'(rx_mem[rx_rp]);
      A_TXO:  rdata = 32'(tx_occ);
      A_RXO:  rdata = 32'(rx_occ);
      A_RXWM: rdata = 32'(rx_wm);
      A_GIE:  rdata = {gie, 31'h0};
      A_ISR:  rdata = 32'(isr);
      A_IER:  rdata = 32'(ier);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 9,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [7:0]    isr,
  input logic [1:0]    ctl,
  input logic          gie,
  input logic          eng_tx_pop,
  input logic          irq
);
  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && !eng_tx_pop && !ctl[1] &&
     !(wr_en && addr == AW'('h040))) |=> tx_cnt == CW'(DEPTH));
  a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('h10C) && rx_cnt == '0) |-> rdata == 32'h0);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[0] && !(wr_en && (addr == AW'('h020) || addr == AW'('h040))))
      |=> isr[0]);
  a_r10_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h040) && wdata == 32'hA)
      |=> (tx_cnt == '0 && rx_cnt == '0 && ctl == 2'b00 && !gie));
endmodule

bind i2c_regbank i2c_regbank_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .isr(isr), .ctl(ctl), .gie(gie), .eng_tx_pop(eng_tx_pop), .irq(irq)
);

// File: tb/tb_i2c_regbank.sv
module tb_i2c_regbank;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic eng_enable, eng_tx_valid, eng_rx_ready, irq;
  logic [9:0] eng_tx_word;
  logic eng_tx_pop = 0, eng_rx_push = 0, eng_bus_busy = 0;
  logic eng_arb_lost = 0, eng_nack = 0;
  logic [7:0] eng_rx_byte = '0;

  int total = 0, fails = 0, mcount = 0;
  logic [9:0] txq[$];
  logic [7:0] rxq[$];

  always #4 clk = ~clk;

  i2c_regbank dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic bw(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic br(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rchk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    br(a, d); chk(req, d, exp);
  endtask

  // driver: a push the model predicts as accepted enters the scoreboard
  task automatic tx_drive(input logic [9:0] w, input bit held);
    if (!held && mcount < 16) begin txq.push_back(w); mcount++; end
    bw(9'h108, {22'h0, w});
  endtask

  // monitor: engine side pops and compares with the scoreboard head
  task automatic tx_take(input string req);
    logic [9:0] e;
    @(negedge clk);
    chk({req, " valid"}, eng_tx_valid, 1'b1);
    e = txq.pop_front(); mcount--;
    chk(req, eng_tx_word, e);
    eng_tx_pop = 1;
    @(negedge clk); eng_tx_pop = 0;
  endtask

  task automatic rx_give(input logic [7:0] b);
    @(negedge clk); eng_rx_byte = b; eng_rx_push = 1;
    if (rxq.size() < 16) rxq.push_back(b);
    @(negedge clk); eng_rx_push = 0;
  endtask

  task automatic rx_take(input string req);
    logic [31:0] d;
    br(9'h10C, d); chk(req, d, {24'h0, rxq.pop_front()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rchk("R1 ctl", 9'h100, 0);
    rchk("R1 gie", 9'h01C, 0);
    rchk("R1 ier", 9'h028, 0);
    rchk("R1 txocc", 9'h114, 0);
    rchk("R1 rxocc", 9'h118, 0);
    rchk("R1 rxwm", 9'h120, 0);
    rchk("R1 status", 9'h104, 32'hC0);
    chk("R1 irq", irq, 0);
    // R7 level causes after reset: tx empty, bus idle, tx half
    rchk("R7 isr idle", 9'h020, 32'h94);
    // R6 enable bit
    bw(9'h100, 1);
    @(negedge clk); chk("R6 eng_enable", eng_enable, 1);
    // R2 ordering with flags, R4 occupancy
    tx_drive(10'h1A0, 0); tx_drive(10'h255, 0); tx_drive(10'h0C3, 0);
    rchk("R4 txocc 3 words", 9'h114, 2);
    rchk("R5 status tx nonempty", 9'h104, 32'h40);
    tx_take("R2 order"); tx_take("R2 order"); tx_take("R2 order");
    rchk("R4 txocc empty", 9'h114, 0);
    // R2 full and drop
    for (int i = 0; i < 17; i++) tx_drive(10'(i * 37 + 5), 0);
    rchk("R5 tx full", 9'h104, 32'h50);
    rchk("R4 txocc full", 9'h114, 15);
    for (int i = 0; i < 16; i++) tx_take("R2 drain");
    @(negedge clk); chk("R2 dropped not stored", eng_tx_valid, 0);
    // R6 tx fifo hold
    tx_drive(10'h011, 0);
    bw(9'h100, 3);
    txq.delete(); mcount = 0;
    tx_drive(10'h022, 1);
    rchk("R6 held empty", 9'h114, 0);
    chk("R6 held no valid", eng_tx_valid, 0);
    bw(9'h100, 1);
    rchk("R6 release still empty", 9'h104, 32'hC0);
    // R3 rx path
    rchk("R3 empty read zero", 9'h10C, 0);
    rchk("R3 empty read no change", 9'h118, 0);
    rx_give(8'h5A); rx_give(8'hC3);
    rchk("R4 rxocc", 9'h118, 1);
    rx_take("R3 order"); rx_take("R3 order");
    for (int i = 0; i < 17; i++) rx_give(8'(i + 8'h40));
    rchk("R5 rx full", 9'h104, 32'hA0);
    @(negedge clk); chk("R3 rx_ready low", eng_rx_ready, 0);
    for (int i = 0; i < 16; i++) rx_take("R3 drain");
    rchk("R3 dropped byte absent", 9'h104, 32'hC0);
    // R5 busy bit
    eng_bus_busy = 1;
    rchk("R5 busy", 9'h104, 32'hC4);
    eng_bus_busy = 0;
    // R8 watermark
    bw(9'h120, 2);
    rx_give(8'h01); rx_give(8'h02);
    bw(9'h020, 32'h08);
    br(9'h020, d); chk("R8 below watermark", d & 8, 0);
    rx_give(8'h03);
    br(9'h020, d); chk("R8 at watermark", d & 8, 8);
    rx_take("R3 wm"); rx_take("R3 wm"); rx_take("R3 wm");
    // R9 sticky and W1C, R7 arb/nack
    @(negedge clk); eng_arb_lost = 1; eng_nack = 1;
    @(negedge clk); eng_arb_lost = 0; eng_nack = 0;
    repeat (2) @(negedge clk);
    br(9'h020, d); chk("R9 sticky arb R7", d & 3, 3);
    bw(9'h020, 0);
    br(9'h020, d); chk("R9 write zero keeps", d & 3, 3);
    bw(9'h020, 1);
    br(9'h020, d); chk("R9 write one clears", d & 3, 2);
    // R10 irq gating
    bw(9'h028, 2);
    chk("R10 gie off", irq, 0);
    bw(9'h01C, 32'h8000_0000);
    @(negedge clk); chk("R10 irq on", irq, 1);
    bw(9'h020, 2);
    @(negedge clk); chk("R10 irq after clear", irq, 0);
    // R11 soft reset
    tx_drive(10'h3FF, 0);
    bw(9'h040, 5);
    rchk("R11 wrong key ctl", 9'h100, 1);
    rchk("R11 wrong key occ", 9'h114, 0);
    chk("R11 wrong key valid", eng_tx_valid, 1);
    bw(9'h040, 32'hA);
    txq.delete(); mcount = 0;
    rchk("R11 ctl", 9'h100, 0);
    rchk("R11 gie", 9'h01C, 0);
    rchk("R11 ier", 9'h028, 0);
    rchk("R11 status", 9'h104, 32'hC0);
    chk("R11 no valid", eng_tx_valid, 0);
    finish_run();
  end
endmodule